// File: doc/BRIEF.md
# Almost-Flag Offset Loader

This block holds the four threshold registers that set the almost-empty and almost-full flags for a pair of FIFOs. The pair carries data in opposite directions. Each FIFO has an empty-side offset (X) and a full-side offset (Y). The surrounding FIFO logic supplies each FIFO's stored-word count and free-location count. The block compares these counts against the offsets and drives four active-low flags, one clock edge later.

The loading method is chosen during a master reset. The reset must be held for several clock edges before it is recognised. There are three methods:

- **Preset:** one of three preset values is written into all four offsets.
- **Parallel:** the offsets start at zero and are then written one per parallel write strobe.
- **Serial:** the offsets start at zero and are then filled by one MSB-first bit stream on a serial data pin, gated by an active-low enable.

A partial reset flushes the FIFO side only. It forces the flags to their empty-FIFO state and leaves the method, the offsets and the loading progress untouched.

Top module: `afl_offset_loader`

## Requirements
- R1: A master reset takes effect only on the fourth and later consecutive rising edges at which `mrst_n` is sampled low. A low pulse covering three or fewer edges changes neither the method nor the offsets.
- R2: A recognised master reset selects the method from `spm_n` and `fsel`, with this encoding:
  - `spm_n`=0 selects serial loading.
  - `spm_n`=1 with `fsel`=00 selects parallel loading.
  - `spm_n`=1 with `fsel`=01, 10 or 11 selects a preset and loads 8, 16 or 64 into all four offsets.
  - Serial and parallel selection clear all four offsets to 0.
- R3: In serial mode, each rising edge with `mrst_n` high and `sen_n` low shifts `sd` into one 4*W-bit chain. The chain order is Y1, X1, Y2, X2, each MSB first. The first bit ends in the MSB of Y1 and the last in the LSB of X2.
- R4: Once 4*W serial bits have been taken, further shift edges leave all offsets unchanged until the next recognised master reset.
- R5: In parallel mode, each rising edge with `pwr` high writes `pdata` into the next offset, in the order Y1, X1, Y2, X2. A fifth and later write is ignored until the next master reset.
- R6: Loading strobes of the method not selected are ignored. This covers `sen_n` in parallel or preset mode and `pwr` in serial or preset mode. Offsets change only on a recognised master reset or on a load step of the selected method.
- R7: `ae1_n` is low exactly when `wcnt1` ≤ X1, and `ae2_n` is low exactly when `wcnt2` ≤ X2. Each flag reflects the count one rising edge after the count is presented.
- R8: `af1_n` is low exactly when `free1` ≤ Y1, and `af2_n` is low exactly when `free2` ≤ Y2. The same one-edge latency applies.
- R9: While `prst_n` is low, the flags are forced one edge later to `ae*_n`=0 and `af*_n`=1. Offsets and method are kept, and after release the flags again follow R7 and R8 with the earlier offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port A clock; all state changes on its rising edge |
| mrst_n | input | 1 | Master reset, active low, qualified over four edges |
| prst_n | input | 1 | Partial reset, active low |
| spm_n | input | 1 | Serial-method select, sampled during master reset |
| fsel | input | 2 | Parallel/preset select, sampled during master reset |
| sen_n | input | 1 | Serial shift enable, active low |
| sd | input | 1 | Serial offset data |
| pwr | input | 1 | Parallel offset write strobe |
| pdata | input | DEPTH_LOG2 | Low-order slice of the port A data bus |
| wcnt1 | input | DEPTH_LOG2+1 | Stored-word count of FIFO 1 |
| free1 | input | DEPTH_LOG2+1 | Free-location count of FIFO 1 |
| wcnt2 | input | DEPTH_LOG2+1 | Stored-word count of FIFO 2 |
| free2 | input | DEPTH_LOG2+1 | Free-location count of FIFO 2 |
| ae1_n | output | 1 | Almost-empty flag of FIFO 1, active low |
| af1_n | output | 1 | Almost-full flag of FIFO 1, active low |
| ae2_n | output | 1 | Almost-empty flag of FIFO 2, active low |
| af2_n | output | 1 | Almost-full flag of FIFO 2, active low |

## Verification
The result timing is as follows:
- A master-reset configuration lands on the fourth low edge.
- A serial or parallel load step lands on the edge that samples it.
- The flags show the offsets and counts in force at the previous edge, so every flag result is due one rising edge after its stimulus.

The bench drives every input on the falling edge and reads the flags on the next falling edge, which falls exactly one rising edge later. Each offset set is measured by sweeping all four counts together through every value from 0 to 2^W. The flag changes are compared against thresholds computed in the bench. The same sweep runs after each reset, load sequence and ignored-strobe pattern.

// File: rtl/afl_pkg.sv
package afl_pkg;

   // Offset loading methods chosen at master reset.
   typedef enum logic [2:0] {
      LM_SERIAL   = 3'd0,
      LM_PARALLEL = 3'd1,
      LM_PRESET_A = 3'd2,
      LM_PRESET_B = 3'd3,
      LM_PRESET_C = 3'd4
   } load_mode_t;

   // Number of offset registers and their slot order (load order).
   localparam int NREG   = 4;
   localparam int SLOT_Y1 = 0;
   localparam int SLOT_X1 = 1;
   localparam int SLOT_Y2 = 2;
   localparam int SLOT_X2 = 3;

   function automatic load_mode_t pick_mode(input logic spm_n, input logic [1:0] fsel);
      load_mode_t m;
      if (!spm_n) begin
         m = LM_SERIAL;
      end else begin
         case (fsel)
            2'b00:   m = LM_PARALLEL;
            2'b01:   m = LM_PRESET_A;
            2'b10:   m = LM_PRESET_B;
            default: m = LM_PRESET_C;
         endcase
      end
      return m;
   endfunction

endpackage

// File: rtl/afl_mode_ctl.sv
module afl_mode_ctl
   import afl_pkg::*;
#(
   parameter int QUAL_EDGES = 4
)(
   input  logic       clk,
   input  logic       mrst_n,
   input  load_mode_t cfg_mode,
   output load_mode_t mode,
   output logic       cfg_apply
);

   localparam int HW = QUAL_EDGES - 1;

   // History of earlier low samples of the master reset.
   logic [HW-1:0] low_hist;

   generate
      if (HW == 1) begin : g_hist_one
         always_ff @(posedge clk) low_hist <= ~mrst_n;
      end else begin : g_hist_shift
         always_ff @(posedge clk) low_hist <= {low_hist[HW-2:0], ~mrst_n};
      end
   endgenerate

   // Current sample low and all earlier HW samples low: reset recognised.
   assign cfg_apply = ~mrst_n & (&low_hist);

   always_ff @(posedge clk) begin
      if (cfg_apply) begin
         mode <= cfg_mode;
      end
   end

endmodule

// File: rtl/afl_offset_store.sv
module afl_offset_store
   import afl_pkg::*;
#(
   parameter int OW    = 10,
   parameter int DEF_A = 8,
   parameter int DEF_B = 16,
   parameter int DEF_C = 64
)(
   input  logic                      clk,
   input  logic                      cfg_apply,
   input  load_mode_t                cfg_mode,
   input  load_mode_t                mode,
   input  logic                      load_en,
   input  logic                      sen_n,
   input  logic                      sd,
   input  logic                      pwr,
   input  logic [OW-1:0]             pdata,
   output logic [NREG-1:0][OW-1:0]   ofs_q
);

   localparam int NBITS = NREG * OW;
   localparam int SCW   = $clog2(NBITS + 1);
   localparam int IW    = $clog2(NREG);
   localparam logic [SCW-1:0] BITS_FULL = SCW'(NBITS);
   localparam logic [SCW-1:0] BIT_ONE   = SCW'(1);
   localparam logic [IW:0]    IDX_FULL  = (IW+1)'(NREG);
   localparam logic [IW:0]    IDX_ONE   = (IW+1)'(1);
   localparam logic [OW-1:0]  PV_A = OW'(DEF_A);
   localparam logic [OW-1:0]  PV_B = OW'(DEF_B);
   localparam logic [OW-1:0]  PV_C = OW'(DEF_C);

   logic [SCW-1:0]  bit_cnt;
   logic [IW:0]     wr_idx;
   logic [NREG-1:0] chain_in;
   logic            ser_step;
   logic            par_step;

   function automatic logic [OW-1:0] preset_of(input load_mode_t m);
      logic [OW-1:0] v;
      case (m)
         LM_PRESET_A: v = PV_A;
         LM_PRESET_B: v = PV_B;
         LM_PRESET_C: v = PV_C;
         default:     v = '0;
      endcase
      return v;
   endfunction

   // Serial chain: the MSB of each later slot feeds the LSB of the slot before it.
   generate
      for (genvar i = 0; i < NREG; i++) begin : g_chain
         if (i == NREG - 1) begin : g_tail
            assign chain_in[i] = sd;
         end else begin : g_link
            assign chain_in[i] = ofs_q[i+1][OW-1];
         end
      end
   endgenerate

   assign ser_step = load_en && (mode == LM_SERIAL) && !sen_n && (bit_cnt != BITS_FULL);
   assign par_step = load_en && (mode == LM_PARALLEL) && pwr && (wr_idx != IDX_FULL);

   always_ff @(posedge clk) begin
      if (cfg_apply) begin
         for (int i = 0; i < NREG; i++) begin
            ofs_q[i] <= preset_of(cfg_mode);
         end
         bit_cnt <= '0;
         wr_idx  <= '0;
      end else if (ser_step) begin
         for (int i = 0; i < NREG; i++) begin
            ofs_q[i] <= {ofs_q[i][OW-2:0], chain_in[i]};
         end
         bit_cnt <= bit_cnt + BIT_ONE;
      end else if (par_step) begin
         ofs_q[wr_idx[IW-1:0]] <= pdata;
         wr_idx <= wr_idx + IDX_ONE;
      end
   end

endmodule

// File: rtl/afl_flag_cmp.sv
module afl_flag_cmp #(
   parameter int OW       = 10,
   parameter bit FLAG_REG = 1'b1
)(
   input  logic          clk,
   input  logic          prst_n,
   input  logic [OW-1:0] x_ofs,
   input  logic [OW-1:0] y_ofs,
   input  logic [OW:0]   count,
   input  logic [OW:0]   space,
   output logic          ae_n,
   output logic          af_n
);

   logic ae_nx;
   logic af_nx;

   // Partial reset shows an empty FIFO: almost-empty asserted, almost-full clear.
   assign ae_nx = prst_n ? (count > {1'b0, x_ofs}) : 1'b0;
   assign af_nx = prst_n ? (space > {1'b0, y_ofs}) : 1'b1;

   generate
      if (FLAG_REG) begin : g_reg
         always_ff @(posedge clk) begin
            ae_n <= ae_nx;
            af_n <= af_nx;
         end
      end else begin : g_comb
         assign ae_n = ae_nx;
         assign af_n = af_nx;
      end
   endgenerate

endmodule

// File: rtl/afl_offset_loader.sv
module afl_offset_loader
   import afl_pkg::*;
#(
   parameter int DEPTH_LOG2 = 10,
   parameter int DEF_A      = 8,
   parameter int DEF_B      = 16,
   parameter int DEF_C      = 64,
   parameter int QUAL_EDGES = 4,
   parameter bit FLAG_REG   = 1'b1
)(
   input  logic                  clk,
   input  logic                  mrst_n,
   input  logic                  prst_n,
   input  logic                  spm_n,
   input  logic [1:0]            fsel,
   input  logic                  sen_n,
   input  logic                  sd,
   input  logic                  pwr,
   input  logic [DEPTH_LOG2-1:0] pdata,
   input  logic [DEPTH_LOG2:0]   wcnt1,
   input  logic [DEPTH_LOG2:0]   free1,
   input  logic [DEPTH_LOG2:0]   wcnt2,
   input  logic [DEPTH_LOG2:0]   free2,
   output logic                  ae1_n,
   output logic                  af1_n,
   output logic                  ae2_n,
   output logic                  af2_n
);

   localparam int OW     = DEPTH_LOG2;
   localparam int CW     = DEPTH_LOG2 + 1;
   localparam int NFIFO  = 2;
   localparam int PV_LIM = 1 << DEPTH_LOG2;

   // Elaboration-time parameter checks.
   generate
      if (DEPTH_LOG2 < 2 || DEPTH_LOG2 > 20) begin : g_bad_depth
         $error("afl_offset_loader: DEPTH_LOG2 must lie in 2..20");
      end
      if (DEF_A < 0 || DEF_B < 0 || DEF_C < 0 ||
          DEF_A >= PV_LIM || DEF_B >= PV_LIM || DEF_C >= PV_LIM) begin : g_bad_preset
         $error("afl_offset_loader: preset offsets must fit in DEPTH_LOG2 bits");
      end
      if (QUAL_EDGES < 2 || QUAL_EDGES > 16) begin : g_bad_qual
         $error("afl_offset_loader: QUAL_EDGES must lie in 2..16");
      end
   endgenerate

   load_mode_t                cfg_mode;
   load_mode_t                mode;
   logic                      cfg_apply;
   logic [NREG-1:0][OW-1:0]   ofs_q;
   logic [NFIFO-1:0][CW-1:0]  wc_v;
   logic [NFIFO-1:0][CW-1:0]  fr_v;
   logic [NFIFO-1:0]          ae_v;
   logic [NFIFO-1:0]          af_v;

   assign cfg_mode = pick_mode(spm_n, fsel);

   afl_mode_ctl #(
      .QUAL_EDGES (QUAL_EDGES)
   ) u_mode (
      .clk       (clk),
      .mrst_n    (mrst_n),
      .cfg_mode  (cfg_mode),
      .mode      (mode),
      .cfg_apply (cfg_apply)
   );

   afl_offset_store #(
      .OW    (OW),
      .DEF_A (DEF_A),
      .DEF_B (DEF_B),
      .DEF_C (DEF_C)
   ) u_store (
      .clk       (clk),
      .cfg_apply (cfg_apply),
      .cfg_mode  (cfg_mode),
      .mode      (mode),
      .load_en   (mrst_n),
      .sen_n     (sen_n),
      .sd        (sd),
      .pwr       (pwr),
      .pdata     (pdata),
      .ofs_q     (ofs_q)
   );

   assign wc_v = {wcnt2, wcnt1};
   assign fr_v = {free2, free1};

   // FIFO f uses offset slots 2f (Y) and 2f+1 (X).
   generate
      for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
         afl_flag_cmp #(
            .OW       (OW),
            .FLAG_REG (FLAG_REG)
         ) u_cmp (
            .clk    (clk),
            .prst_n (prst_n),
            .x_ofs  (ofs_q[2*f+1]),
            .y_ofs  (ofs_q[2*f]),
            .count  (wc_v[f]),
            .space  (fr_v[f]),
            .ae_n   (ae_v[f]),
            .af_n   (af_v[f])
         );
      end
   endgenerate

   assign ae1_n = ae_v[0];
   assign af1_n = af_v[0];
   assign ae2_n = ae_v[1];
   assign af2_n = af_v[1];

endmodule

// File: rtl/afl_offset_loader_chk.sv
module afl_offset_loader_chk #(
   parameter int OW         = 10,
   parameter int DEF_A      = 8,
   parameter int DEF_B      = 16,
   parameter int DEF_C      = 64,
   parameter int QUAL_EDGES = 4,
   parameter bit FLAG_REG   = 1'b1
)(
   input logic                 clk,
   input logic                 mrst_n,
   input logic                 prst_n,
   input logic                 spm_n,
   input logic [1:0]           fsel,
   input logic                 sen_n,
   input logic                 pwr,
   input logic [OW:0]          wcnt1,
   input logic [OW:0]          free1,
   input logic [OW:0]          wcnt2,
   input logic [OW:0]          free2,
   input logic                 ae1_n,
   input logic                 af1_n,
   input logic                 ae2_n,
   input logic                 af2_n,
   input logic [3:0][OW-1:0]   ofs
);

   localparam int HW    = QUAL_EDGES - 1;
   localparam int NBITS = 4 * OW;
   localparam int SCW   = $clog2(NBITS + 1);
   localparam logic [SCW-1:0] S_FULL = SCW'(NBITS);
   localparam logic [SCW-1:0] S_ONE  = SCW'(1);
   localparam logic [OW-1:0]  PA = OW'(DEF_A);

   logic [HW-1:0]  lows;
   logic           qual;
   logic           seen = 1'b0;
   logic           live = 1'b0;
   logic           smode = 1'b0;
   logic [SCW-1:0] scount = '0;

   generate
      if (HW == 1) begin : g_one
         always_ff @(posedge clk) lows <= ~mrst_n;
      end else begin : g_shift
         always_ff @(posedge clk) lows <= {lows[HW-2:0], ~mrst_n};
      end
   endgenerate

   assign qual = ~mrst_n & (&lows);

   always_ff @(posedge clk) begin
      seen <= seen | qual;
      live <= seen;
      if (qual) begin
         smode  <= ~spm_n;
         scount <= '0;
      end else if (mrst_n && smode && !sen_n && scount != S_FULL) begin
         scount <= scount + S_ONE;
      end
   end

   // R2
   preset_a_chk: assert property (@(posedge clk) disable iff (!live)
      (qual && spm_n && fsel == 2'b01) |=>
      (ofs[0] == PA && ofs[1] == PA && ofs[2] == PA && ofs[3] == PA));

   // R2
   serial_clear_chk: assert property (@(posedge clk) disable iff (!live)
      (qual && !spm_n) |=> (ofs == '0));

   // R4
   serial_full_chk: assert property (@(posedge clk) disable iff (!live)
      (mrst_n && smode && scount == S_FULL && !sen_n) |=> $stable(ofs));

   // R6
   no_strobe_chk: assert property (@(posedge clk) disable iff (!live)
      (mrst_n && sen_n && !pwr) |=> $stable(ofs));

   generate
      if (FLAG_REG) begin : g_reg_chk
         // R7
         ae_level_chk: assert property (@(posedge clk) disable iff (!live)
            $past(prst_n) |-> (ae1_n == ($past(wcnt1) > {1'b0, $past(ofs[1])}) &&
                               ae2_n == ($past(wcnt2) > {1'b0, $past(ofs[3])})));
         // R8
         af_level_chk: assert property (@(posedge clk) disable iff (!live)
            $past(prst_n) |-> (af1_n == ($past(free1) > {1'b0, $past(ofs[0])}) &&
                               af2_n == ($past(free2) > {1'b0, $past(ofs[2])})));
         // R9
         partial_flag_chk: assert property (@(posedge clk) disable iff (!live)
            !$past(prst_n) |-> (!ae1_n && af1_n && !ae2_n && af2_n));
      end else begin : g_comb_chk
         // R7
         ae_level_chk: assert property (@(posedge clk) disable iff (!live)
            prst_n |-> (ae1_n == (wcnt1 > {1'b0, ofs[1]}) &&
                        ae2_n == (wcnt2 > {1'b0, ofs[3]})));
         // R8
         af_level_chk: assert property (@(posedge clk) disable iff (!live)
            prst_n |-> (af1_n == (free1 > {1'b0, ofs[0]}) &&
                        af2_n == (free2 > {1'b0, ofs[2]})));
         // R9
         partial_flag_chk: assert property (@(posedge clk) disable iff (!live)
            !prst_n |-> (!ae1_n && af1_n && !ae2_n && af2_n));
      end
   endgenerate

endmodule

bind afl_offset_loader afl_offset_loader_chk #(
   .OW         (DEPTH_LOG2),
   .DEF_A      (DEF_A),
   .DEF_B      (DEF_B),
   .DEF_C      (DEF_C),
   .QUAL_EDGES (QUAL_EDGES),
   .FLAG_REG   (FLAG_REG)
) u_chk (
   .clk    (clk),
   .mrst_n (mrst_n),
   .prst_n (prst_n),
   .spm_n  (spm_n),
   .fsel   (fsel),
   .sen_n  (sen_n),
   .pwr    (pwr),
   .wcnt1  (wcnt1),
   .free1  (free1),
   .wcnt2  (wcnt2),
   .free2  (free2),
   .ae1_n  (ae1_n),
   .af1_n  (af1_n),
   .ae2_n  (ae2_n),
   .af2_n  (af2_n),
   .ofs    (ofs_q)
);

// File: tb/sim_afl_offset_loader.sv
module sim_afl_offset_loader;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 7;
   localparam int CMAX       = 1 << W;
   localparam int LIMIT      = 150000;

   logic         clk = 1'b0;
   logic         mrst_n = 1'b1;
   logic         prst_n = 1'b1;
   logic         spm_n = 1'b1;
   logic [1:0]   fsel = 2'b01;
   logic         sen_n = 1'b1;
   logic         sd = 1'b0;
   logic         pwr = 1'b0;
   logic [W-1:0] pdata = '0;
   logic [W:0]   wcnt1 = '0;
   logic [W:0]   free1 = '0;
   logic [W:0]   wcnt2 = '0;
   logic [W:0]   free2 = '0;
   logic         ae1_n, af1_n, ae2_n, af2_n;

   int  n_cmp = 0;
   int  n_bad = 0;
   int  cyc   = 0;
   bit  done  = 1'b0;

   afl_offset_loader #(
      .DEPTH_LOG2 (W)
   ) u0 (
      .clk    (clk),
      .mrst_n (mrst_n),
      .prst_n (prst_n),
      .spm_n  (spm_n),
      .fsel   (fsel),
      .sen_n  (sen_n),
      .sd     (sd),
      .pwr    (pwr),
      .pdata  (pdata),
      .wcnt1  (wcnt1),
      .free1  (free1),
      .wcnt2  (wcnt2),
      .free2  (free2),
      .ae1_n  (ae1_n),
      .af1_n  (af1_n),
      .ae2_n  (ae2_n),
      .af2_n  (af2_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > LIMIT && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual cycles %0d expected at most %0d", cyc, LIMIT);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Caller stands at a falling edge; each step presents a count and reads one edge later.
   task automatic check_flags(input int y1, input int x1, input int y2, input int x2, input string req);
      for (int c = 0; c <= CMAX; c++) begin
         wcnt1 = (W+1)'(c);
         free1 = (W+1)'(c);
         wcnt2 = (W+1)'(c);
         free2 = (W+1)'(c);
         @(negedge clk);
         chk(req, $sformatf("ae1_n at count %0d", c), int'(ae1_n), int'(c > x1));
         chk(req, $sformatf("af1_n at free %0d", c),  int'(af1_n), int'(c > y1));
         chk(req, $sformatf("ae2_n at count %0d", c), int'(ae2_n), int'(c > x2));
         chk(req, $sformatf("af2_n at free %0d", c),  int'(af2_n), int'(c > y2));
      end
   endtask

   task automatic do_mrst(input logic spm, input logic [1:0] fs, input int edges);
      spm_n  = spm;
      fsel   = fs;
      mrst_n = 1'b0;
      repeat (edges) @(negedge clk);
      mrst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic shift_bits(input logic [63:0] bits, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         sen_n = 1'b0;
         sd    = bits[i];
         @(negedge clk);
      end
      sen_n = 1'b1;
      sd    = 1'b0;
   endtask

   task automatic par_write(input int v);
      pwr   = 1'b1;
      pdata = W'(v);
      @(negedge clk);
      pwr   = 1'b0;
   endtask

   initial begin
      logic [63:0] stream;
      @(negedge clk);

      // R2: preset 8 (spm_n=1, fsel=01)
      do_mrst(1'b1, 2'b01, 4);
      check_flags(8, 8, 8, 8, "R2");
      // R2: preset 16 (fsel=10), preset 64 (fsel=11)
      do_mrst(1'b1, 2'b10, 5);
      check_flags(16, 16, 16, 16, "R2");
      do_mrst(1'b1, 2'b11, 4);
      check_flags(64, 64, 64, 64, "R2");

      // R1: three low edges are not a master reset
      do_mrst(1'b1, 2'b01, 3);
      check_flags(64, 64, 64, 64, "R1");
      do_mrst(1'b0, 2'b00, 2);
      check_flags(64, 64, 64, 64, "R1");

      // R6: preset mode ignores shift and write strobes
      shift_bits(64'h5A5A, 16);
      par_write(3);
      check_flags(64, 64, 64, 64, "R6");

      // R2: serial selection clears offsets
      do_mrst(1'b0, 2'b11, 4);
      check_flags(0, 0, 0, 0, "R2");

      // R3: stream Y1=5, X1=100, Y2=127, X2=1, MSB first, with a gap and an ignored write
      stream = 64'({7'd5, 7'd100, 7'd127, 7'd1});
      shift_bits(stream >> 18, 10);
      par_write(77);
      @(negedge clk);
      shift_bits(stream, 18);
      check_flags(5, 100, 127, 1, "R3");

      // R4: bits beyond the stream are ignored
      shift_bits(64'h2AAA, 14);
      check_flags(5, 100, 127, 1, "R4");

      // R9: partial reset forces flags and keeps offsets
      prst_n = 1'b0;
      wcnt1 = (W+1)'(CMAX); free1 = '0; wcnt2 = (W+1)'(CMAX); free2 = '0;
      @(negedge clk);
      chk("R9", "ae1_n in partial reset", int'(ae1_n), 0);
      chk("R9", "af1_n in partial reset", int'(af1_n), 1);
      chk("R9", "ae2_n in partial reset", int'(ae2_n), 0);
      chk("R9", "af2_n in partial reset", int'(af2_n), 1);
      @(negedge clk);
      prst_n = 1'b1;
      check_flags(5, 100, 127, 1, "R9");

      // R5: parallel load order, only low bits carried, fifth write ignored
      do_mrst(1'b1, 2'b00, 4);
      check_flags(0, 0, 0, 0, "R2");
      shift_bits(64'h7F, 7);
      par_write(9);
      par_write(126);
      @(negedge clk);
      par_write(64);
      par_write(0);
      par_write(33);
      check_flags(9, 126, 64, 0, "R5");
      shift_bits(64'h7F, 7);
      check_flags(9, 126, 64, 0, "R6");

      // R7, R8: fifos independent with distinct counts
      wcnt1 = (W+1)'(126); free1 = (W+1)'(10); wcnt2 = (W+1)'(1); free2 = (W+1)'(64);
      @(negedge clk);
      chk("R7", "ae1_n count 126 vs X1 126", int'(ae1_n), 0);
      chk("R8", "af1_n free 10 vs Y1 9",     int'(af1_n), 1);
      chk("R7", "ae2_n count 1 vs X2 0",     int'(ae2_n), 1);
      chk("R8", "af2_n free 64 vs Y2 64",    int'(af2_n), 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule